// File: doc/BRIEF.md
# Four-Bit Stack Arithmetic Unit

This block is a 4-bit arithmetic and logic unit tied to an eight-entry expression stack. It has no register addresses. Binary operations take their left operand from the entry just below the top of the stack and their right operand from the top. They consume both and leave a single result on top. Unary shifts, rotates and the inversion rework the top entry in place. Every completed operation updates a carry/borrow flag and a branch flag, which together form a small condition code register.

A host loads operands through a push port and removes values through a pop strobe. The current top value and the depth can be read at all times. The host launches an operation by presenting an operation code with a one-cycle start strobe. Each operation takes one machine cycle of two clocks, and a busy output marks the second clock. Over-filling or under-running the stack sets a sticky error flag and leaves the stored entries alone.

Top module: `stack_alu`

## Requirements
- R1: After reset the depth is 0, the top value reads 0, and the carry, branch, error and busy outputs are all 0.
- R2: A push places push_data on top and raises the depth by one. A pop removes the top entry, exposes the entry below it and lowers the depth by one. The stack holds up to 8 entries.
- R3: A push onto a full stack, or a pop from an empty one, sets the error flag and changes neither the depth nor the stored values. Only reset clears the error flag.
- R4: When the unit is idle, an op_start is accepted on a rising edge. busy is then high for exactly the next clock, and the result is on the top of stack after the second rising edge. While busy is high, push, pop and op_start are ignored.
- R5: Code 0 (add) and code 1 (add with carry) form TOS-1 + TOS (+ carry). Carry becomes the carry out of bit 3, and the depth drops by one.
- R6: Code 2 (subtract) and code 3 (subtract with borrow) form TOS-1 - TOS (- carry) modulo 16. Carry becomes 1 when a borrow occurs, and the depth drops by one.
- R7: Codes 4, 5 and 6 (AND, OR, XOR of TOS-1 and TOS) lower the depth by one. Code 11 inverts TOS in place. All four clear carry.
- R8: Code 7 shifts TOS left and code 8 shifts TOS right, with a zero filling the vacated bit. The bit shifted out goes to carry, and the depth is unchanged.
- R9: Code 9 rotates TOS left through carry (old carry enters bit 0, bit 3 goes to carry). Code 10 rotates TOS right through carry (old carry enters bit 3, bit 0 goes to carry). The depth is unchanged.
- R10: After every completed operation with codes 0 to 11, the branch flag is 1 exactly when the result is zero. The flags change at no other time.
- R11: An operation started with fewer stack entries than it needs sets the error flag. It does not raise busy, and it changes neither the stack nor the flags. Binary operations need two entries and unary operations need one.
- R12: Codes 12 to 15 take a machine cycle (busy for one clock) but leave the stack and the flags unchanged.
- R13: When the unit is idle and several requests arrive in the same cycle, op_start wins over push, and push wins over pop. The losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_start | input | 1 | One-cycle strobe that launches an operation |
| op_code | input | 4 | Operation code sampled with op_start |
| push_en | input | 1 | Push push_data onto the stack |
| push_data | input | 4 | Value to push |
| pop_en | input | 1 | Remove the top entry |
| tos_data | output | 4 | Current top of stack (0 when empty) |
| stack_depth | output | 4 | Number of valid entries |
| busy | output | 1 | Second clock of a machine cycle |
| carry_flag | output | 1 | Carry/borrow flag |
| branch_flag | output | 1 | Branch flag, set on a zero result |
| stack_err | output | 1 | Sticky overflow/underflow flag |

## Verification
On every cycle, the assertions check the following. The depth never exceeds its bound, and no push is ever issued to a full stack. A binary write-back always lowers the depth by one. busy never lasts more than one clock. The error flag never falls outside reset. The flags move only at the end of a machine cycle, and the branch flag then agrees with the value actually written to the top. The arithmetic values, the carry and borrow chains, the rotation through carry, the refusal of short-operand operations, the undefined codes and the priority among simultaneous requests can only be shown by the bench's directed scenarios, which compare the top of stack and the flags against hand-derived results.

// File: rtl/stack_alu_pkg.sv
package stack_alu_pkg;

  localparam int unsigned DW = 4;

  localparam logic [3:0] OPC_ADD  = 4'd0;
  localparam logic [3:0] OPC_ADDC = 4'd1;
  localparam logic [3:0] OPC_SUB  = 4'd2;
  localparam logic [3:0] OPC_SUBB = 4'd3;
  localparam logic [3:0] OPC_AND  = 4'd4;
  localparam logic [3:0] OPC_OR   = 4'd5;
  localparam logic [3:0] OPC_XOR  = 4'd6;
  localparam logic [3:0] OPC_SHL  = 4'd7;
  localparam logic [3:0] OPC_SHR  = 4'd8;
  localparam logic [3:0] OPC_ROL  = 4'd9;
  localparam logic [3:0] OPC_ROR  = 4'd10;
  localparam logic [3:0] OPC_NOT  = 4'd11;

  typedef enum logic [2:0] {
    SCMD_NONE,
    SCMD_PUSH,
    SCMD_POP,
    SCMD_WB_BIN,
    SCMD_WB_UN
  } stk_cmd_e;

  // operand count required by a code: 2 binary, 1 unary, 0 undefined
  function automatic logic [1:0] op_arity(input logic [3:0] opc);
    if (opc <= OPC_XOR)      op_arity = 2'd2;
    else if (opc <= OPC_NOT) op_arity = 2'd1;
    else                     op_arity = 2'd0;
  endfunction

endpackage

// File: rtl/stack_alu_rst_sync.sv
module stack_alu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/stack_alu_core.sv
module stack_alu_core
  import stack_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [3:0]   opc,
  input  logic [W-1:0] lhs,     // TOS-1
  input  logic [W-1:0] rhs,     // TOS
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);

  logic [W:0] sum_w;
  logic [W:0] dif_w;

  always_comb begin
    sum_w = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, (opc == OPC_ADDC) & cin};
    dif_w = {1'b0, lhs} - {1'b0, rhs} - {{W{1'b0}}, (opc == OPC_SUBB) & cin};
  end

  always_comb begin
    res  = rhs;
    cout = cin;
    unique case (opc)
      OPC_ADD, OPC_ADDC: begin res = sum_w[W-1:0]; cout = sum_w[W]; end
      OPC_SUB, OPC_SUBB: begin res = dif_w[W-1:0]; cout = dif_w[W]; end
      OPC_AND: begin res = lhs & rhs; cout = 1'b0; end
      OPC_OR:  begin res = lhs | rhs; cout = 1'b0; end
      OPC_XOR: begin res = lhs ^ rhs; cout = 1'b0; end
      OPC_NOT: begin res = ~rhs;      cout = 1'b0; end
      OPC_SHL: begin res = {rhs[W-2:0], 1'b0}; cout = rhs[W-1]; end
      OPC_SHR: begin res = {1'b0, rhs[W-1:1]}; cout = rhs[0];   end
      OPC_ROL: begin res = {rhs[W-2:0], cin};  cout = rhs[W-1]; end
      OPC_ROR: begin res = {cin, rhs[W-1:1]};  cout = rhs[0];   end
      default: begin res = rhs; cout = cin; end
    endcase
  end

endmodule

// File: rtl/stack_alu_stack.sv
module stack_alu_stack
  import stack_alu_pkg::*;
#(
  parameter int unsigned W     = DW,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_cmd_e      cmd,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  tos,
  output logic [W-1:0]  nos,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [CW-1:0]    cnt_n;
  logic [DEPTH-1:0] we;
  logic [CW-1:0]    cm1, cm2;
  logic [AW-1:0]    push_idx, top_idx, nos_idx, wr_idx;

  always_comb begin
    cm1      = cnt - CW'(1);
    cm2      = cnt - CW'(2);
    push_idx = cnt[AW-1:0];
    top_idx  = cm1[AW-1:0];
    nos_idx  = cm2[AW-1:0];
    full     = (cnt == CW'(DEPTH));
    empty    = (cnt == '0);
    tos      = empty ? '0 : mem[top_idx];
    nos      = (cnt < CW'(2)) ? '0 : mem[nos_idx];
  end

  // next-state: count and the single entry written this cycle
  always_comb begin
    cnt_n  = cnt;
    wr_idx = top_idx;
    we     = '0;
    unique case (cmd)
      SCMD_PUSH:   begin cnt_n = cnt + CW'(1); wr_idx = push_idx; we[push_idx] = 1'b1; end
      SCMD_POP:    begin cnt_n = cnt - CW'(1); end
      SCMD_WB_BIN: begin cnt_n = cnt - CW'(1); wr_idx = nos_idx; we[nos_idx] = 1'b1; end
      SCMD_WB_UN:  begin wr_idx = top_idx; we[top_idx] = 1'b1; end
      default:     begin cnt_n = cnt; end
    endcase
  end

  logic unused_idx;
  assign unused_idx = ^wr_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (cmd != SCMD_NONE) cnt <= cnt_n;
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem[gi] <= '0;
      else if (we[gi]) mem[gi] <= wdata;
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R3
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SCMD_PUSH) |-> (cnt < CW'(DEPTH)));
  // R3
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SCMD_POP) |-> (cnt != '0));
  // R5
  bin_wb_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == SCMD_WB_BIN) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/stack_alu_ctrl.sv
module stack_alu_ctrl
  import stack_alu_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned CW = 4,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic [3:0]    op_code,
  input  logic          push_en,
  input  logic [W-1:0]  push_data,
  input  logic          pop_en,
  input  logic [W-1:0]  tos,
  input  logic [W-1:0]  nos,
  input  logic [CW-1:0] cnt,
  input  logic          full,
  input  logic          empty,
  input  logic [W-1:0]  alu_res,
  input  logic          alu_cout,
  output logic [3:0]    op_q,
  output logic [W-1:0]  lhs_q,
  output logic [W-1:0]  rhs_q,
  output stk_cmd_e      cmd,
  output logic [W-1:0]  wdata,
  output logic          busy_q,
  output logic          carry_q,
  output logic          zero_q,
  output logic          err_q
);

  logic       busy_n, carry_n, zero_n, err_n, accept;
  logic [1:0] need_start, need_q;

  always_comb begin
    need_start = op_arity(op_code);
    need_q     = op_arity(op_q);
  end

  always_comb begin
    busy_n  = 1'b0;
    carry_n = carry_q;
    zero_n  = zero_q;
    err_n   = err_q;
    accept  = 1'b0;
    cmd     = SCMD_NONE;
    wdata   = push_data;
    if (busy_q) begin
      if (need_q != 2'd0) begin
        cmd     = (need_q == 2'd2) ? SCMD_WB_BIN : SCMD_WB_UN;
        wdata   = alu_res;
        carry_n = alu_cout;
        zero_n  = (alu_res == '0);
      end
    end else if (op_start) begin
      if (cnt < CW'(need_start)) begin
        err_n = 1'b1;
      end else begin
        accept = 1'b1;
        busy_n = 1'b1;
      end
    end else if (push_en) begin
      if (full) err_n = 1'b1;
      else      cmd   = SCMD_PUSH;
    end else if (pop_en) begin
      if (empty) err_n = 1'b1;
      else       cmd   = SCMD_POP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      carry_q <= carry_n;
      zero_q  <= zero_n;
      err_q   <= err_n;
    end
  end

  // operand capture only when an operation is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      lhs_q <= '0;
      rhs_q <= '0;
    end else if (accept) begin
      op_q  <= op_code;
      lhs_q <= nos;
      rhs_q <= tos;
    end
  end

  // R4
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);
  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> ($stable(carry_q) && $stable(zero_q)));
  // R10
  zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (need_q != 2'd0)) |=> (zero_q == (tos == '0)));
  // R2
  depth_param_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (cnt == CW'(DEPTH)));

endmodule

// File: rtl/stack_alu.sv
module stack_alu
  import stack_alu_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic [3:0]    op_code,
  input  logic          push_en,
  input  logic [DW-1:0] push_data,
  input  logic          pop_en,
  output logic [DW-1:0] tos_data,
  output logic [CW-1:0] stack_depth,
  output logic          busy,
  output logic          carry_flag,
  output logic          branch_flag,
  output logic          stack_err
);

  logic          rst_sn;
  stk_cmd_e      cmd;
  logic [DW-1:0] wdata, tos, nos, lhs_q, rhs_q, alu_res;
  logic [3:0]    op_q;
  logic [CW-1:0] cnt;
  logic          full, empty, alu_cout, busy_q, carry_q, zero_q, err_q;

  stack_alu_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  stack_alu_stack #(.W(DW), .DEPTH(DEPTH)) i_stack (
    .clk(clk), .rst_n(rst_sn), .cmd(cmd), .wdata(wdata),
    .tos(tos), .nos(nos), .cnt(cnt), .full(full), .empty(empty)
  );

  stack_alu_core #(.W(DW)) i_core (
    .opc(op_q), .lhs(lhs_q), .rhs(rhs_q), .cin(carry_q),
    .res(alu_res), .cout(alu_cout)
  );

  stack_alu_ctrl #(.W(DW), .CW(CW), .DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_sn), .op_start(op_start), .op_code(op_code),
    .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
    .tos(tos), .nos(nos), .cnt(cnt), .full(full), .empty(empty),
    .alu_res(alu_res), .alu_cout(alu_cout), .op_q(op_q),
    .lhs_q(lhs_q), .rhs_q(rhs_q), .cmd(cmd), .wdata(wdata),
    .busy_q(busy_q), .carry_q(carry_q), .zero_q(zero_q), .err_q(err_q)
  );

  assign tos_data    = tos;
  assign stack_depth = cnt;
  assign busy        = busy_q;
  assign carry_flag  = carry_q;
  assign branch_flag = zero_q;
  assign stack_err   = err_q;

endmodule

// File: tb/test_stack_alu.sv
module test_stack_alu;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_start, push_en, pop_en;
  logic [3:0] op_code, push_data;
  logic [3:0] tos_data, stack_depth;
  logic       busy, carry_flag, branch_flag, stack_err;
  int         checks = 0;
  int         errors = 0;
  logic       busy_seen;

  always #4 clk = ~clk;

  stack_alu i_stack_alu (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
    .push_en(push_en), .push_data(push_data), .pop_en(pop_en),
    .tos_data(tos_data), .stack_depth(stack_depth), .busy(busy),
    .carry_flag(carry_flag), .branch_flag(branch_flag), .stack_err(stack_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int tos, input int dep,
                           input int c, input int z, input int e);
    chk(req, "tos", int'(tos_data), tos);
    chk(req, "depth", int'(stack_depth), dep);
    chk(req, "carry", int'(carry_flag), c);
    chk(req, "branch", int'(branch_flag), z);
    chk(req, "err", int'(stack_err), e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; op_start = 1'b0; push_en = 1'b0; pop_en = 1'b0;
    op_code = '0; push_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input logic [3:0] v);
    @(negedge clk); push_en = 1'b1; push_data = v;
    @(negedge clk); push_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); pop_en = 1'b1;
    @(negedge clk); pop_en = 1'b0;
  endtask

  // launches op, records busy in the second clock, returns after result is visible
  task automatic run_op(input logic [3:0] code);
    @(negedge clk); op_code = code; op_start = 1'b1;
    @(negedge clk); op_start = 1'b0; busy_seen = busy;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk_state("R1", 0, 0, 0, 0, 0);
    chk("R1", "busy", int'(busy), 0);
  endtask

  task automatic t_push_pop();
    do_reset();
    push(4'h3); push(4'h5); push(4'h9);
    chk_state("R2", 9, 3, 0, 0, 0);
    pop();
    chk_state("R2", 5, 2, 0, 0, 0);
    pop(); pop();
    chk_state("R2", 0, 0, 0, 0, 0);
  endtask

  task automatic t_add();
    do_reset();
    push(4'h9); push(4'h8);
    run_op(4'd0);
    chk("R4", "busy in 2nd clock", int'(busy_seen), 1);
    chk_state("R5", 1, 1, 1, 0, 0);
    push(4'hE);
    run_op(4'd1);                       // 1+14+1 = 16
    chk_state("R5", 0, 1, 1, 1, 0);     // branch set on zero: R10
  endtask

  task automatic t_sub();
    do_reset();
    push(4'h3); push(4'h5);
    run_op(4'd2);                       // 3-5 = E, borrow
    chk_state("R6", 14, 1, 1, 0, 0);
    push(4'hE);
    run_op(4'd3);                       // E-E-1 = F, borrow
    chk_state("R6", 15, 1, 1, 0, 0);
    push(4'h5);
    run_op(4'd2);                       // F-5 = A, no borrow
    chk_state("R6", 10, 1, 0, 0, 0);
  endtask

  task automatic t_logic();
    do_reset();
    push(4'h9); push(4'h8); run_op(4'd0); // carry = 1
    push(4'hC); push(4'hA);
    run_op(4'd4);                       // C & A = 8, carry cleared
    chk_state("R7", 8, 2, 0, 0, 0);
    push(4'h3); run_op(4'd5);           // 8|3 = B
    chk_state("R7", 11, 2, 0, 0, 0);
    push(4'hB); run_op(4'd6);           // B^B = 0
    chk_state("R7", 0, 2, 0, 1, 0);
    run_op(4'd11);                      // ~0 = F
    chk_state("R7", 15, 2, 0, 0, 0);
  endtask

  task automatic t_shift();
    do_reset();
    push(4'h9);
    run_op(4'd7);                       // 9<<1 = 2, carry 1
    chk_state("R8", 2, 1, 1, 0, 0);
    run_op(4'd8);                       // 2>>1 = 1, carry 0
    chk_state("R8", 1, 1, 0, 0, 0);
    run_op(4'd8);                       // 1>>1 = 0, carry 1
    chk_state("R8", 0, 1, 1, 1, 0);
  endtask

  task automatic t_rotate();
    do_reset();
    push(4'h8);
    run_op(4'd7);                       // 0, carry 1
    run_op(4'd10);                      // ROR: {1,000} = 8, carry 0
    chk_state("R9", 8, 1, 0, 0, 0);
    run_op(4'd9);                       // ROL: {000,0} = 0, carry 1
    chk_state("R9", 0, 1, 1, 1, 0);
    run_op(4'd9);                       // ROL: {000,1} = 1, carry 0
    chk_state("R9", 1, 1, 0, 0, 0);
  endtask

  task automatic t_busy_ignore();
    do_reset();
    push(4'h2); push(4'h4);
    @(negedge clk); op_code = 4'd0; op_start = 1'b1;
    @(negedge clk); op_start = 1'b0; push_en = 1'b1; push_data = 4'h7;
    chk("R4", "busy", int'(busy), 1);
    @(negedge clk); push_en = 1'b0;
    chk_state("R4", 6, 1, 0, 0, 0);     // push during busy dropped
    chk("R4", "busy after", int'(busy), 0);
  endtask

  task automatic t_full_empty();
    do_reset();
    for (int i = 1; i <= 8; i++) push(4'(i));
    chk_state("R2", 8, 8, 0, 0, 0);
    push(4'hF);
    chk_state("R3", 8, 8, 0, 0, 1);
    pop();
    chk_state("R3", 7, 7, 0, 0, 1);     // sticky and contents intact
    do_reset();
    pop();
    chk_state("R3", 0, 0, 0, 0, 1);
  endtask

  task automatic t_short();
    do_reset();
    push(4'h5);
    run_op(4'd0);
    chk("R11", "busy", int'(busy_seen), 0);
    chk_state("R11", 5, 1, 0, 0, 1);
    do_reset();
    run_op(4'd7);
    chk_state("R11", 0, 0, 0, 0, 1);
  endtask

  task automatic t_undef();
    do_reset();
    push(4'h8); run_op(4'd7);           // tos 0, carry 1, branch 1
    push(4'h6);
    run_op(4'd13);
    chk("R12", "busy", int'(busy_seen), 1);
    chk_state("R12", 6, 2, 1, 1, 0);
  endtask

  task automatic t_priority();
    do_reset();
    push(4'h1); push(4'h2);
    @(negedge clk); op_code = 4'd0; op_start = 1'b1; push_en = 1'b1;
    push_data = 4'h9; pop_en = 1'b1;
    @(negedge clk); op_start = 1'b0; push_en = 1'b0; pop_en = 1'b0;
    @(negedge clk);
    chk_state("R13", 3, 1, 0, 0, 0);
    @(negedge clk); push_en = 1'b1; pop_en = 1'b1; push_data = 4'hA;
    @(negedge clk); push_en = 1'b0; pop_en = 1'b0;
    chk_state("R13", 10, 2, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_push_pop();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    t_rotate();
    t_busy_ignore();
    t_full_empty();
    t_short();
    t_undef();
    t_priority();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule